// File: doc/BRIEF.md
# Iterative Parallel-Prefix Word Adder

This block adds or subtracts two k-bit words modulo 2^k. It resolves the carries with whole-word propagate and generate steps that each double the span of bits they cover. One step runs per clock. A single set of shift, AND and XOR/OR logic is reused on every cycle, in place of a full prefix tree laid out in space. The shift distance is picked from a step counter.

A one-cycle `start` pulse, taken only while the block is idle, captures both operands and the mode bit. Subtraction adds the bitwise inverse of the second operand and injects a carry of one at the bottom. To carry that injected one through every step, each shifted generate word is filled with ones from below, and generate terms are merged with OR. Addition fills with zeros and merges with XOR.

The number of cycles depends only on the width and never on the operand values. The result is held on the output until the next operation finishes.

Top module: `pp_word_adder`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy` and `done` are low and `result` is zero.
- R2: With `sub_mode` = 0 at acceptance, the result reported with `done` equals (a + b) mod 2^WIDTH.
- R3: With `sub_mode` = 1 at acceptance, the result reported with `done` equals (a − b) mod 2^WIDTH. The wrap from 0 − 1 to all ones is included.
- R4: Let L = max(ceil(log2(WIDTH−1)), 1) and S = L + 1. `busy` is high for exactly S cycles after the accepting edge, and `done` is high in the cycle after the last of them. For WIDTH = 32, S = 6.
- R5: The latency of R4 is the same for every operand pair and for both modes.
- R6: `done` is a pulse of exactly one cycle, and `busy` is low while `done` is high.
- R7: While `busy` is high, `start`, `a_in`, `b_in` and `sub_mode` are ignored. The next result belongs to the operation already accepted.
- R8: `result` changes only in a cycle where `done` is high. It otherwise holds its value.
- R9: A `start` seen while idle is accepted, and `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted only while idle |
| sub_mode | input | 1 | 0 = add, 1 = subtract; sampled on acceptance |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand (subtrahend in subtract mode) |
| busy | output | 1 | High while combining steps run |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH, held between completions |

## Verification
The bound checker records the operands of every accepted request and compares each completed result against true modular arithmetic. It also counts the busy cycles of every run against the fixed step count, and it watches the pulse shape and the stability of the held result on every cycle.

Two matters are left to the bench scenarios. Only they show that a request raised in the middle of a run leaves no trace, and that the reset values are right. The sweep of every operand pair in both modes at a small width shows that no carry pattern, including full-length chains and mode-dependent fills, changes the result or the latency.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [0:0] {
        PP_IDLE = 1'b0,
        PP_RUN  = 1'b1
    } pp_state_e;

    // Number of doubling steps needed to cover a carry span of width-1 bits.
    function automatic int loop_steps(input int width);
        int s;
        s = $clog2(width - 1);
        return (s < 1) ? 1 : s;
    endfunction

    // Total combining cycles: the doubling steps plus one trailing generate step.
    function automatic int total_steps(input int width);
        return loop_steps(width) + 1;
    endfunction

endpackage

// File: rtl/pp_step.sv
module pp_step #(
    parameter int WIDTH = 32,
    parameter int SH_W  = 5
) (
    input  logic             sub,
    input  logic [SH_W-1:0]  sh_amt,
    input  logic [WIDTH-1:0] p_cur,
    input  logic [WIDTH-1:0] g_cur,
    output logic [WIDTH-1:0] p_nxt,
    output logic [WIDTH-1:0] g_nxt
);
    logic [WIDTH-1:0] fill;
    logic [WIDTH-1:0] g_sh;
    logic [WIDTH-1:0] term;

    always_comb begin
        // Low bits vacated by the shift carry the injected carry in subtract mode.
        fill  = sub ? ~({WIDTH{1'b1}} << sh_amt) : '0;
        g_sh  = (g_cur << sh_amt) | fill;
        term  = p_cur & g_sh;
        g_nxt = sub ? (g_cur | term) : (g_cur ^ term);
        p_nxt = p_cur & (p_cur << sh_amt);
    end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SH_W  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            load,
    output logic            step,
    output logic            last,
    output logic [SH_W-1:0] sh_amt,
    output logic            busy,
    output logic            done
);
    localparam int LOOP  = loop_steps(WIDTH);
    localparam int TOTAL = total_steps(WIDTH);
    localparam int CNT_W = $clog2(TOTAL + 1);

    pp_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [CNT_W-1:0] sh_idx;

    always_comb begin
        load   = (state_q == PP_IDLE) && start;
        step   = (state_q == PP_RUN);
        last   = step && (cnt_q == CNT_W'(TOTAL - 1));
        // The trailing generate step reuses the widest doubling distance.
        sh_idx = (cnt_q < CNT_W'(LOOP)) ? cnt_q : CNT_W'(LOOP - 1);
        sh_amt = SH_W'(1) << sh_idx;
        busy   = step;
        done   = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PP_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                PP_IDLE: begin
                    if (start) begin
                        state_q <= PP_RUN;
                        cnt_q   <= '0;
                    end
                end
                PP_RUN: begin
                    if (cnt_q == CNT_W'(TOTAL - 1)) begin
                        state_q <= PP_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pp_word_adder.sv
module pp_word_adder
    import pp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sub_mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int SH_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;

    logic             load, step, last;
    logic [SH_W-1:0]  sh_amt;
    logic [WIDTH-1:0] p_q, g_q, x_q, res_q;
    logic [WIDTH-1:0] p_n, g_n, b_eff;
    logic             sub_q;

    pp_ctrl #(.WIDTH(WIDTH), .SH_W(SH_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load   (load),
        .step   (step),
        .last   (last),
        .sh_amt (sh_amt),
        .busy   (busy),
        .done   (done)
    );

    pp_step #(.WIDTH(WIDTH), .SH_W(SH_W)) u_step (
        .sub    (sub_q),
        .sh_amt (sh_amt),
        .p_cur  (p_q),
        .g_cur  (g_q),
        .p_nxt  (p_n),
        .g_nxt  (g_n)
    );

    assign b_eff = sub_mode ? ~b_in : b_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q   <= '0;
            g_q   <= '0;
            x_q   <= '0;
            sub_q <= 1'b0;
            res_q <= '0;
        end else if (load) begin
            p_q   <= a_in ^ b_eff;
            g_q   <= a_in & b_eff;
            x_q   <= a_in ^ b_eff;
            sub_q <= sub_mode;
        end else if (step) begin
            g_q <= g_n;
            if (!last) begin
                p_q <= p_n;
            end else begin
                res_q <= x_q ^ {g_n[WIDTH-2:0], sub_q};
            end
        end
    end

    assign result = res_q;
endmodule

// File: rtl/pp_word_adder_chk.sv
module pp_word_adder_chk
    import pp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             sub_mode,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result
);
    localparam int TOTAL = total_steps(WIDTH);

    logic [WIDTH-1:0] a_c, b_c;
    logic             s_c;
    int unsigned      busy_cnt;
    logic [WIDTH-1:0] expect_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_c      <= '0;
            b_c      <= '0;
            s_c      <= 1'b0;
            busy_cnt <= 0;
        end else begin
            if (start && !busy) begin
                a_c <= a_in;
                b_c <= b_in;
                s_c <= sub_mode;
            end
            busy_cnt <= busy ? busy_cnt + 1 : 0;
        end
    end

    assign expect_v = s_c ? (a_c - b_c) : (a_c + b_c);

    assert_sum_ok_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !s_c) |-> (result == expect_v));
    assert_diff_ok_R3: assert property (@(posedge clk) disable iff (rst)
        (done && s_c) |-> (result == expect_v));
    assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == TOTAL));
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idle_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

bind pp_word_adder pp_word_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sub_mode (sub_mode),
    .a_in     (a_in),
    .b_in     (b_in),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/test_pp_word_adder.sv
module test_pp_word_adder;
    localparam int SW = 6;   // small width swept exhaustively
    localparam int SS = 4;   // combining steps for SW: max(ceil(log2 5),1)+1
    localparam int BS = 6;   // combining steps for 32 bits

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;    // 125 MHz

    logic          s_start = 0, s_sub = 0;
    logic [SW-1:0] s_a = 0, s_b = 0;
    logic          s_busy, s_done;
    logic [SW-1:0] s_res;

    logic          w_start = 0, w_sub = 0;
    logic [31:0]   w_a = 0, w_b = 0;
    logic          w_busy, w_done;
    logic [31:0]   w_res;

    int n_chk = 0;
    int n_bad = 0;

    pp_word_adder #(.WIDTH(SW)) i_pp_word_adder (
        .clk(clk), .rst(rst), .start(s_start), .sub_mode(s_sub),
        .a_in(s_a), .b_in(s_b), .busy(s_busy), .done(s_done), .result(s_res)
    );

    pp_word_adder #(.WIDTH(32)) i_pp_word_adder_w32 (
        .clk(clk), .rst(rst), .start(w_start), .sub_mode(w_sub),
        .a_in(w_a), .b_in(w_b), .busy(w_busy), .done(w_done), .result(w_res)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_small(input int a, input int b, input bit sub);
        int n;
        int exp;
        @(negedge clk);
        s_start = 1; s_a = SW'(a); s_b = SW'(b); s_sub = sub;
        @(negedge clk);
        s_start = 0;
        n = 1;
        while (!s_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        exp = sub ? ((a - b + 64) % 64) : ((a + b) % 64);
        check(n == SS + 1, "R4/R5 small latency", n, SS + 1);
        check(s_res == SW'(exp), sub ? "R3 small diff" : "R2 small sum", s_res, exp);
    endtask

    task automatic run_big(input logic [31:0] a, input logic [31:0] b, input bit sub,
                           input bit poke, input string req);
        int n;
        logic [31:0] exp;
        @(negedge clk);
        w_start = 1; w_a = a; w_b = b; w_sub = sub;
        @(negedge clk);
        w_start = 0;
        n = 1;
        if (poke) begin
            // R7: a request raised mid-run with other operands and mode must be ignored
            @(negedge clk);
            n++;
            w_start = 1; w_a = ~a; w_b = 32'h1234; w_sub = ~sub;
            @(negedge clk);
            n++;
            w_start = 0;
        end
        while (!w_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        exp = sub ? (a - b) : (a + b);
        check(n == BS + 1, "R4 w32 latency", n, BS + 1);
        check(w_res == exp, req, w_res, exp);
        @(negedge clk);
        check(w_done == 1'b0, "R6 done pulse", w_done, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        check(s_busy == 0 && s_done == 0 && s_res == 0, "R1 reset small", s_res, 0);
        check(w_busy == 0 && w_done == 0 && w_res == 0, "R1 reset w32", w_res, 0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(w_busy == 0 && w_done == 0 && w_res == 0, "R1 after release", w_res, 0);

        // R9: accepted start raises busy on the next cycle
        w_start = 1; w_a = 32'd3; w_b = 32'd4; w_sub = 0;
        @(negedge clk);
        w_start = 0;
        check(w_busy == 1, "R9 busy after start", w_busy, 1);
        repeat (BS + 2) @(negedge clk);

        run_big(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R2 wrap to zero");
        run_big(32'hAAAA_AAAA, 32'h5555_5556, 0, 0, "R2 full carry chain");
        run_big(32'h8000_0000, 32'h8000_0000, 0, 0, "R2 top carry dropped");
        run_big(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, "R2 long chain");
        run_big(32'h0000_0000, 32'h0000_0001, 1, 0, "R3 zero minus one");
        run_big(32'h1234_5678, 32'h1234_5678, 1, 0, "R3 equal operands");
        run_big(32'h0000_0005, 32'h0000_0007, 1, 0, "R3 negative result");
        run_big(32'hDEAD_BEEF, 32'h0BAD_F00D, 0, 1, "R7 add ignores mid-run start");
        run_big(32'h0000_1000, 32'h0000_0001, 1, 1, "R7 sub ignores mid-run start");

        // R8: result holds with no new request
        begin
            logic [31:0] held;
            held = w_res;
            repeat (5) @(negedge clk);
            check(w_res == held && w_done == 0, "R8 result held", w_res, held);
        end

        for (int sub = 0; sub < 2; sub++)
            for (int a = 0; a < 64; a++)
                for (int b = 0; b < 64; b++)
                    run_small(a, b, sub[0]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule